// File: doc/BRIEF.md
# Two-Wire Register Slave with Persistent Pointer

This block is the serial front end of a bank of 8-bit registers. The host reaches it over a two-wire bus with one clock line and one open-drain data line. The block samples both lines on the system clock and detects START, repeated START and STOP conditions. It answers one fixed 7-bit device address. A pointer register chooses which register every access uses. That pointer is loaded only by the first byte after the address in a write. It keeps its value across transactions and does not step on its own.

Three transfer shapes are supported:
- **Pointer-only write:** address+W, pointer byte, STOP.
- **Register write:** address+W, pointer byte, data byte, STOP.
- **Register read:** address+R, then the slave shifts out the selected register with the most significant bit first, the host replies NACK, then STOP. A read may follow a pointer-only write directly through a repeated START.

On the register side, the block has a plain port to an external register file. This port carries the address (always the pointer), a one-cycle write strobe with its data, and a read-data input that the register file drives combinationally.

**States.** IDLE waits for START. ADDR receives the address byte. ADDR_ACK, CMD_ACK and DATA_ACK each hold the data line low for the acknowledge clock. CMD receives the pointer byte. DATA receives the data byte. RD_BYTE drives the eight read bits. RD_ACK releases the line while the host answers. IGNORE keeps the line released until the next START or STOP.

**Transitions.**
- From any state, STOP goes to IDLE and START goes to ADDR.
- When the ADDR byte ends, the block goes to ADDR_ACK if the address matches and to IGNORE if it does not.
- When ADDR_ACK ends, the block goes to RD_BYTE for a read and to CMD for a write.
- CMD goes to CMD_ACK, which goes to DATA.
- DATA goes to DATA_ACK, which goes to IGNORE.
- RD_BYTE goes to RD_ACK after eight bits, and RD_ACK goes to IGNORE.

Top module: `smb_ptr_slave`

## Requirements
- R1: During and right after reset, `sda_oe` and `reg_wr_en` are 0 and `reg_addr` is 0.
- R2: After an address byte equal to `DEV_ADDR` (bits 7:1 of the byte, bit 0 = direction, 0 write and 1 read), and after each accepted pointer or data byte, the slave pulls SDA low for the ninth clock. It never pulls SDA low while the host drives a data bit, and it only begins pulling low after an SCL falling edge.
- R3: The first byte after address+W loads the pointer (shown on `reg_addr`) and never causes a register write.
- R4: A pointer-only write changes no register. The pointer it sets persists across STOP and selects the register for a later read.
- R5: In a register write, the data byte is acknowledged and produces exactly one single-cycle `reg_wr_en` pulse with `reg_addr` = pointer and `reg_wr_data` = the byte.
- R6: A read started directly with address+R returns the register at the current pointer, most significant bit first.
- R7: A repeated START right after the acknowledge of a pointer byte begins a new address phase, and a read then returns the newly selected register with no STOP in between.
- R8: On an address mismatch, SDA is never pulled low until the next START or STOP, no register is written, and the pointer is unchanged.
- R9: Data bytes after the first in a write are not acknowledged and are discarded.
- R10: The pointer does not change because of a read or a register write (no auto-increment).
- R11: A STOP (SDA rising while SCL is high) in the middle of a byte ends the transfer with no register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When 1, pull the data line low; the line is never driven high |
| reg_addr | output | 8 | Register address (the pointer) |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_data | output | 8 | Register write data |
| reg_rd_data | input | 8 | Register read data at `reg_addr` |

## Verification
On every cycle, the assertions check the following:
- the pointer changes only on entry to the pointer-acknowledge state;
- the pointer holds while a read byte is being shifted out;
- write strobes are single-cycle and occur only in the data-acknowledge state;
- the data line is released in IDLE and IGNORE;
- the data line is pulled low only right after an SCL fall.

The bench's transaction scenarios are the only way to show the end-to-end behaviours:
- the bit order of read data;
- that a pointer persists across STOP;
- the repeated-START read;
- NACKs for a foreign address and for surplus bytes;
- an aborted write.

It shows these by comparing against a behavioural model of the register file and pointer.

// File: rtl/smb_pkg.sv
package smb_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_IGNORE
    } smb_state_e;
endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] pipe_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe_q[i] <= '1;
        end else begin
            pipe_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
        end
    end

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/smb_bus_events.sv
module smb_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/smb_ptr_slave.sv
module smb_ptr_slave
    import smb_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h2E,
    parameter int         BYTE_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] reg_addr,
    output logic              reg_wr_en,
    output logic [BYTE_W-1:0] reg_wr_data,
    input  logic [BYTE_W-1:0] reg_rd_data
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic [1:0] sync_s;
    logic       scl_s, sda_s;
    logic       scl_rise, scl_fall, start_det, stop_det;

    smb_sync #(.W(2), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({scl_i, sda_i}),
        .q_o   (sync_s)
    );
    assign scl_s = sync_s[1];
    assign sda_s = sync_s[0];

    smb_bus_events u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    smb_state_e        state_q, state_d;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic              got_byte_q;
    logic [BYTE_W-1:0] rx_sh_q, tx_sh_q, ptr_q;
    logic              rw_q, wr_q;
    logic              rx_state, byte_end;

    assign rx_state = (state_q == ST_ADDR) || (state_q == ST_CMD) || (state_q == ST_DATA);
    assign byte_end = rx_state && got_byte_q && scl_fall;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (stop_det) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_ADDR:     if (byte_end)
                                 state_d = (rx_sh_q[BYTE_W-1:1] == DEV_ADDR) ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall) state_d = rw_q ? ST_RD_BYTE : ST_CMD;
                ST_CMD:      if (byte_end) state_d = ST_CMD_ACK;
                ST_CMD_ACK:  if (scl_fall) state_d = ST_DATA;
                ST_DATA:     if (byte_end) state_d = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall) state_d = ST_IGNORE;
                ST_RD_BYTE:  if (scl_fall && bit_cnt_q == LAST_BIT) state_d = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall) state_d = ST_IGNORE;
                ST_IGNORE:   state_d = ST_IGNORE;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath: shifters, bit counter, pointer, write strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q  <= '0;
            got_byte_q <= 1'b0;
            rx_sh_q    <= '0;
            tx_sh_q    <= '0;
            ptr_q      <= '0;
            rw_q       <= 1'b0;
            wr_q       <= 1'b0;
        end else begin
            wr_q <= 1'b0;
            if (start_det || stop_det) begin
                bit_cnt_q  <= '0;
                got_byte_q <= 1'b0;
            end else if (byte_end) begin
                bit_cnt_q  <= '0;
                got_byte_q <= 1'b0;
                if (state_q == ST_ADDR) rw_q  <= rx_sh_q[0];
                if (state_q == ST_CMD)  ptr_q <= rx_sh_q;
                if (state_q == ST_DATA) wr_q  <= 1'b1;
            end else if (rx_state && scl_rise && !got_byte_q) begin
                rx_sh_q <= {rx_sh_q[BYTE_W-2:0], sda_s};
                if (bit_cnt_q == LAST_BIT) got_byte_q <= 1'b1;
                else                       bit_cnt_q  <= bit_cnt_q + 1'b1;
            end else if (state_q == ST_ADDR_ACK && scl_fall && rw_q) begin
                tx_sh_q   <= reg_rd_data;
                bit_cnt_q <= '0;
            end else if (state_q == ST_RD_BYTE && scl_fall && bit_cnt_q != LAST_BIT) begin
                tx_sh_q   <= {tx_sh_q[BYTE_W-2:0], 1'b0};
                bit_cnt_q <= bit_cnt_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_ADDR_ACK, ST_CMD_ACK, ST_DATA_ACK: sda_oe = 1'b1;
            ST_RD_BYTE:                           sda_oe = ~tx_sh_q[BYTE_W-1];
            default:                              sda_oe = 1'b0;
        endcase
        reg_addr    = ptr_q;
        reg_wr_en   = wr_q;
        reg_wr_data = rx_sh_q;
    end

    // R3
    ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ptr_q) |-> state_q == ST_CMD_ACK);
    // R10
    ptr_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD_BYTE || state_q == ST_RD_ACK) |-> $stable(ptr_q));
    // R5
    wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);
    // R5
    wr_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> state_q == ST_DATA_ACK);
    // R8
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IGNORE || state_q == ST_IDLE) |-> !sda_oe);
    // R2
    pull_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall));
endmodule

// File: tb/smb_ptr_slave_bench.sv
module smb_ptr_slave_bench;
    localparam logic [6:0] DEV = 7'h2E;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe, reg_wr_en;
    logic [7:0] reg_addr, reg_wr_data, reg_rd_data;
    logic       sda_bus;
    logic [7:0] rf [256];
    logic [7:0] mdl [256];
    logic [15:0] exp_wr_q [$];
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    smb_ptr_slave #(.DEV_ADDR(DEV), .BYTE_W(8)) u_smb_ptr_slave (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl),
        .sda_i       (sda_bus),
        .sda_oe      (sda_oe),
        .reg_addr    (reg_addr),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_data (reg_wr_data),
        .reg_rd_data (reg_rd_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) rf[i] <= 8'(i * 7 + 3);
        end else if (reg_wr_en) begin
            rf[reg_addr] <= reg_wr_data;
        end
    end
    assign reg_rd_data = rf[reg_addr];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // every clock: any write strobe must match the model's next expected write (R5, R8, R9, R11)
    always @(negedge clk) begin
        if (rst_n && reg_wr_en) begin
            if (exp_wr_q.size() == 0) begin
                check(1'b0, "R8/R9/R11 unexpected write", {reg_addr, reg_wr_data}, 0);
            end else begin
                logic [15:0] e;
                e = exp_wr_q.pop_front();
                check({reg_addr, reg_wr_data} == e, "R5 write addr/data", {reg_addr, reg_wr_data}, e);
            end
        end
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(8);
        scl = 1'b1;   wt(8);
        sda_m = 1'b0; wt(8);
        scl = 1'b0;
    endtask

    task automatic bus_stop();
        wt(6); sda_m = 1'b0; wt(6);
        scl = 1'b1; wt(8);
        sda_m = 1'b1; wt(8);
    endtask

    task automatic bit_out(input bit b, inout bit drv_seen);
        wt(6); sda_m = b; wt(10);
        scl = 1'b1; wt(8);
        if (sda_oe) drv_seen = 1'b1;
        wt(8);
        scl = 1'b0;
    endtask

    task automatic byte_out(input logic [7:0] v, output bit ack_n);
        bit drv;
        drv = 1'b0;
        for (int i = 7; i >= 0; i--) bit_out(v[i], drv);
        check(!drv, "R2 released during host bits", drv, 0);
        wt(6); sda_m = 1'b1; wt(10);
        scl = 1'b1; wt(8);
        ack_n = sda_bus;
        wt(8);
        scl = 1'b0;
    endtask

    task automatic byte_in(output logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            wt(6); sda_m = 1'b1; wt(10);
            scl = 1'b1; wt(8);
            v[i] = sda_bus;
            wt(8);
            scl = 1'b0;
        end
        wt(6); sda_m = 1'b1; wt(10);   // host NACK
        scl = 1'b1; wt(16);
        scl = 1'b0;
    endtask

    task automatic do_read(input string tag, input logic [7:0] exp);
        bit a;
        logic [7:0] v;
        bus_start();
        byte_out({DEV, 1'b1}, a);
        check(a == 1'b0, "R2 address ACK on read", a, 0);
        byte_in(v);
        bus_stop();
        check(v == exp, tag, v, exp);
    endtask

    initial begin
        bit a;
        bit drv;
        logic [7:0] v;
        for (int i = 0; i < 256; i++) mdl[i] = 8'(i * 7 + 3);
        wt(5);
        // R1
        check(sda_oe == 1'b0, "R1 sda_oe in reset", sda_oe, 0);
        check(reg_wr_en == 1'b0, "R1 reg_wr_en in reset", reg_wr_en, 0);
        rst_n = 1'b1;
        wt(5);
        check(reg_addr == 8'h00, "R1 pointer after reset", reg_addr, 0);

        // R6: read with no pointer write returns register 0
        do_read("R6 read at reset pointer", mdl[0]);
        check(reg_addr == 8'h00, "R10 pointer after read", reg_addr, 0);

        // R5: register write
        bus_start();
        byte_out({DEV, 1'b0}, a);
        check(a == 1'b0, "R2 address ACK on write", a, 0);
        byte_out(8'h12, a);
        check(a == 1'b0, "R2 pointer byte ACK", a, 0);
        check(reg_addr == 8'h12, "R3 pointer loaded", reg_addr, 8'h12);
        exp_wr_q.push_back({8'h12, 8'hA5}); mdl[8'h12] = 8'hA5;
        byte_out(8'hA5, a);
        check(a == 1'b0, "R5 data byte ACK", a, 0);
        bus_stop();
        check(reg_addr == 8'h12, "R10 pointer after write", reg_addr, 8'h12);
        check(exp_wr_q.size() == 0, "R5 write happened", exp_wr_q.size(), 0);

        // R4: pointer-only write, persists across STOP
        bus_start();
        byte_out({DEV, 1'b0}, a);
        byte_out(8'h40, a);
        check(a == 1'b0, "R4 pointer byte ACK", a, 0);
        bus_stop();
        wt(20);
        check(reg_addr == 8'h40, "R4 pointer persists", reg_addr, 8'h40);
        do_read("R4 read after pointer-only write", mdl[8'h40]);
        do_read("R10 second read no increment", mdl[8'h40]);

        // R7: pointer write then repeated START read
        bus_start();
        byte_out({DEV, 1'b0}, a);
        byte_out(8'h12, a);
        bus_start();
        byte_out({DEV, 1'b1}, a);
        check(a == 1'b0, "R7 address ACK after repeated START", a, 0);
        byte_in(v);
        bus_stop();
        check(v == mdl[8'h12], "R7 repeated START read", v, mdl[8'h12]);

        // R8: foreign address
        bus_start();
        byte_out({DEV ^ 7'h01, 1'b0}, a);
        check(a == 1'b1, "R8 mismatch NACK", a, 1);
        byte_out(8'h55, a);
        check(a == 1'b1, "R8 no ACK after mismatch", a, 1);
        byte_out(8'h11, a);
        bus_stop();
        check(reg_addr == 8'h12, "R8 pointer unchanged", reg_addr, 8'h12);

        // R9: surplus data byte NACKed
        bus_start();
        byte_out({DEV, 1'b0}, a);
        byte_out(8'h20, a);
        exp_wr_q.push_back({8'h20, 8'h3C}); mdl[8'h20] = 8'h3C;
        byte_out(8'h3C, a);
        byte_out(8'h77, a);
        check(a == 1'b1, "R9 surplus byte NACK", a, 1);
        bus_stop();
        check(reg_addr == 8'h20, "R9 pointer after surplus", reg_addr, 8'h20);
        do_read("R9 surplus discarded", mdl[8'h20]);

        // R11: STOP in the middle of the data byte
        bus_start();
        byte_out({DEV, 1'b0}, a);
        byte_out(8'h31, a);
        drv = 1'b0;
        for (int i = 0; i < 4; i++) bit_out(1'b0, drv);
        bus_stop();
        wt(20);
        check(reg_addr == 8'h31, "R11 pointer kept after abort", reg_addr, 8'h31);
        do_read("R11 aborted write left register", mdl[8'h31]);
        check(exp_wr_q.size() == 0, "R11 no pending writes", exp_wr_q.size(), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule